// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port on a plain 32-bit register bus: a byte address, a write strobe, write data and read data. Each pin has a direction bit and an output-level bit. The block drives a per-pin output enable and a per-pin output level, and it samples the pin levels through a two-flop synchronizer.

Software never needs a read-modify-write. To change direction it writes ones to a set register or to a clear register. To change output levels it writes one of two half-port registers. Each of these carries a per-bit update mask in its upper 16 bits and the new levels in its lower 16 bits. An output level can be loaded while its pin is still an input. The level is kept and appears on the pin when the pin is turned into an output.

Reads are combinational from the address. Writes take effect at the rising clock edge on which the strobe is high. Interrupt detection, pad electrical details and bus protocol adapters are outside this block.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to byte address 0x00 turns every pin whose data bit is 1 into an output (its `pin_oe` bit goes to 1 after that edge). Pins whose data bit is 0 keep their direction.
- R2: A write to byte address 0x04 turns every pin whose data bit is 1 into an input (its `pin_oe` bit goes to 0). Pins whose data bit is 0 keep their direction.
- R3: The output register at byte address 0x08 controls pins 0 to 15. The one at 0x0C controls pins 16 to 31, with data bit k acting on pin 16+k. A write to one half never changes the other half.
- R4: In an output register write, data bit 16+k is the update mask for pin k of that half and data bit k is its new level. Pins whose mask bit is 0 keep their level.
- R5: A read of byte address 0x10 returns the levels of `pin_in` through a two-stage synchronizer. A change applied before a rising edge becomes visible after the second rising edge and not after the first.
- R6: An output level written while the pin is an input is kept on `pin_out`. It is driven, with `pin_oe` = 1, once the pin becomes an output.
- R7: After reset all pins are inputs (`pin_oe` = 0), all output levels are 0, and the synchronizer stages hold 0.
- R8: A read of 0x00 or 0x04 returns the direction vector, with 1 meaning output. A read of 0x08 or 0x0C returns that half's output levels in bits 15:0 and 0 in bits 31:16.
- R9: A read of any other byte address returns 0. A write to any other address, including the read-only address 0x10, changes neither direction nor output levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Sampled pin levels |
| pin_oe | output | 32 | Per-pin output enable (1 = output) |
| pin_out | output | 32 | Per-pin output level |

## Verification
The bench walks a single bit through the set and clear registers and then mixes random set and clear writes. A design that applied zero bits, or swapped the two registers, would show a wrong `pin_oe` at once. Random masked writes to both halves check that unmasked pins hold their level and that the high half lands on pins 16 to 31. A shifted mask field or a cross-half write would corrupt the neighbouring pins. Every one of the 256 byte addresses is read, and writes are aimed at unmapped and read-only addresses, so any decode alias shows up as nonzero data or a changed register. The input path is sampled one edge and two edges after each change, which catches a synchronizer with one stage too few or too many.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_OUT_LO  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_HI  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_PIN_IN  = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_OUT_LO,
        SEL_OUT_HI,
        SEL_PIN_IN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_DIR_SET) s = SEL_DIR_SET;
        if (a == OFS_DIR_CLR) s = SEL_DIR_CLR;
        if (a == OFS_OUT_LO)  s = SEL_OUT_LO;
        if (a == OFS_OUT_HI)  s = SEL_OUT_HI;
        if (a == OFS_PIN_IN)  s = SEL_PIN_IN;
        return s;
    endfunction

endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (set_en) begin
            dir_q <= dir_q | wdata;
        end else if (clr_en) begin
            dir_q <= dir_q & ~wdata;
        end
    end

    AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((dir_q & $past(wdata)) == $past(wdata))
                   && (((dir_q ^ $past(dir_q)) & ~$past(wdata)) == '0)); // R1

    AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> ((dir_q & $past(wdata)) == '0)
                   && (((dir_q ^ $past(dir_q)) & ~$past(wdata)) == '0)); // R2

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(dir_q)); // R9

endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [HW-1:0] mask,
    input  logic [HW-1:0] val,
    output logic [HW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= (q & ~mask) | (val & mask);
        end
    end

    AST_OUT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(q)) & ~$past(mask)) == '0)); // R4

    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((q ^ $past(val)) & $past(mask)) == '0)); // R4

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q)); // R3

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] sync_q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [NPINS-1:0]     bus_wdata,
    output logic [NPINS-1:0]     bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_oe,
    output logic [NPINS-1:0]     pin_out
);

    localparam int HW     = NPINS / 2;
    localparam int NHALF  = 2;

    reg_sel_e          sel;
    logic [NPINS-1:0]  dir_q;
    logic [NPINS-1:0]  in_sync;
    logic [NPINS-1:0]  out_q;
    logic [NHALF-1:0]  half_wr;

    assign sel = decode_addr(bus_addr);

    gpio_dir_reg #(.W(NPINS)) i_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (bus_wr && (sel == SEL_DIR_SET)),
        .clr_en (bus_wr && (sel == SEL_DIR_CLR)),
        .wdata  (bus_wdata),
        .dir_q  (dir_q)
    );

    assign half_wr[0] = bus_wr && (sel == SEL_OUT_LO);
    assign half_wr[1] = bus_wr && (sel == SEL_OUT_HI);

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        gpio_out_half #(.HW(HW)) i_half (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (half_wr[h]),
            .mask  (bus_wdata[NPINS-1:HW]),
            .val   (bus_wdata[HW-1:0]),
            .q     (out_q[h*HW +: HW])
        );
    end

    gpio_in_sync #(.W(NPINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .sync_q (in_sync)
    );

    always_comb begin
        unique case (sel)
            SEL_DIR_SET, SEL_DIR_CLR: bus_rdata = dir_q;
            SEL_OUT_LO:               bus_rdata = {{HW{1'b0}}, out_q[HW-1:0]};
            SEL_OUT_HI:               bus_rdata = {{HW{1'b0}}, out_q[NPINS-1:HW]};
            SEL_PIN_IN:               bus_rdata = in_sync;
            default:                  bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_q;
    assign pin_out = out_q;

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == '0)); // R9

    AST_HALF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        half_wr[0] |=> $stable(out_q[NPINS-1:HW])); // R3

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_DIR_SET)) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R1

endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [31:0] exp_dir = '0;
    logic [31:0] exp_out = '0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #5 clk = ~clk;

    gpio_mask_port i_gpio_mask_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic chk_all(input string tag);
        rd_chk(8'h00, exp_dir, {tag, " dir@00 R8"});
        rd_chk(8'h04, exp_dir, {tag, " dir@04 R8"});
        rd_chk(8'h08, {16'h0, exp_out[15:0]}, {tag, " lo R3 R8"});
        rd_chk(8'h0C, {16'h0, exp_out[31:16]}, {tag, " hi R3 R8"});
        chk({tag, " pin_oe"}, pin_oe, exp_dir);
        chk({tag, " pin_out"}, pin_out, exp_out);
    endtask

    function automatic logic [31:0] apply_half(input logic [31:0] cur, input logic hi,
                                               input logic [31:0] d);
        logic [31:0] m;
        logic [31:0] v;
        m = hi ? {d[31:16], 16'h0} : {16'h0, d[31:16]};
        v = hi ? {d[15:0], 16'h0}  : {16'h0, d[15:0]};
        return (cur & ~m) | (v & m);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        chk("R7 pin_oe reset", pin_oe, 32'h0);
        chk("R7 pin_out reset", pin_out, 32'h0);
        rd_chk(8'h10, 32'h0, "R7 sync reset");
        chk_all("R7");

        // R6: preload while input, then enable
        wr(8'h08, 32'hFFFF_A5A5);
        exp_out = apply_half(exp_out, 1'b0, 32'hFFFF_A5A5);
        chk("R6 still input", pin_oe, 32'h0);
        chk("R6 level held", pin_out, 32'h0000_A5A5);
        wr(8'h00, 32'h0000_FFFF);
        exp_dir = 32'h0000_FFFF;
        chk("R6 driven", pin_oe & pin_out, 32'h0000_A5A5);
        wr(8'h04, 32'hFFFF_FFFF);
        exp_dir = '0;
        chk_all("R6 cleared");

        // R1/R2: walking single bit
        for (int i = 0; i < 32; i++) begin
            wr(8'h00, 32'h1 << i);
            exp_dir = exp_dir | (32'h1 << i);
            chk("R1 walk set", pin_oe, exp_dir);
        end
        for (int i = 0; i < 32; i++) begin
            wr(8'h04, 32'h1 << i);
            exp_dir = exp_dir & ~(32'h1 << i);
            chk("R2 walk clear", pin_oe, exp_dir);
        end

        // R1/R2: random mix
        for (int i = 0; i < 64; i++) begin
            step_lfsr();
            if (lfsr[3]) begin
                wr(8'h00, lfsr);
                exp_dir = exp_dir | lfsr;
                chk("R1 rand set", pin_oe, exp_dir);
            end else begin
                wr(8'h04, lfsr);
                exp_dir = exp_dir & ~lfsr;
                chk("R2 rand clear", pin_oe, exp_dir);
            end
        end
        chk_all("R1 R2 final");

        // R3/R4: random masked half writes
        for (int i = 0; i < 128; i++) begin
            step_lfsr();
            if (lfsr[7]) begin
                wr(8'h0C, lfsr);
                exp_out = apply_half(exp_out, 1'b1, lfsr);
            end else begin
                wr(8'h08, lfsr);
                exp_out = apply_half(exp_out, 1'b0, lfsr);
            end
            chk("R4 masked level", pin_out, exp_out);
        end
        wr(8'h0C, 32'h0000_FFFF);
        chk("R4 zero mask keeps", pin_out, exp_out);
        wr(8'h0C, 32'hFFFF_1234);
        exp_out = {16'h1234, exp_out[15:0]};
        chk("R3 high half lands", pin_out, exp_out);
        chk_all("R3 R4 final");

        // R9: exhaustive read sweep of unmapped addresses
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h00 && a != 8'h04 && a != 8'h08 && a != 8'h0C && a != 8'h10)
                rd_chk(a[7:0], 32'h0, "R9 unmapped read");
        end
        // R9: writes to unmapped and read-only addresses
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h09, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        chk_all("R9 ignored writes");

        // R5: two-stage input path
        for (int i = 0; i < 20; i++) begin
            logic [31:0] prev;
            step_lfsr();
            prev = pin_in;
            @(negedge clk);
            bus_addr = 8'h10;
            pin_in   = lfsr;
            @(negedge clk);
            #1;
            chk("R5 one edge old", bus_rdata, prev);
            @(negedge clk);
            #1;
            chk("R5 two edges new", bus_rdata, lfsr);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule